// File: doc/BRIEF.md
# Analog Channel Scan Sequencer

This block decides which analog input channel the converter samples next and when a conversion may begin. Software programs a low and a high channel limit, together with a scan-enable bit and a gain field. A pointer walks from the low limit towards the high limit, one channel per conversion. When the high channel has been sampled, the pointer returns to the low limit. The range may run through channel 15 back to 0 when the low limit is greater than the high limit.

A conversion is triggered in one of two ways. In software mode it comes from a one-cycle start strobe. In hardware mode it comes from either a timer tick or an external pin, and the pin is synchronized and edge-detected before use. Each conversion is a start/done handshake with an external converter model. Scan mode has a second rule: a single trigger runs conversions from the current channel up to the high limit, and one busy flag covers the whole run. Any write of the channel or control settings opens a settling window of a parameterized number of clock cycles (10 µs of clock time), and a further write restarts that window. Triggers that arrive during the window, or while a conversion or scan is in progress, are dropped.

Top module: `adc_scan_sequencer`

## Requirements
- R1: A pulse on `cfg_wr_chan` stores `cfg_lo` and `cfg_hi` (4-bit channel numbers) into `rd_lo`/`rd_hi` and loads `cur_chan` with `cfg_lo`. All three are visible in the cycle after the write.
- R2: Each conversion issued advances `cur_chan` to the next channel. After the high limit it goes to the low limit. Otherwise it goes to the channel plus one, modulo 16, so low=14 and high=2 give 14, 15, 0, 1, 2, 14.
- R3: A write on `cfg_wr_chan` or `cfg_wr_ctl` raises `settling` in the next cycle and holds it for exactly `SETTLE_CYCLES` cycles. A later write restarts the full count.
- R4: A trigger is ignored while `settling` is high and also in the same cycle as a configuration write. `busy` stays low and no `conv_start` is produced.
- R5: With `rd_scan_en`=0, one accepted trigger produces exactly one one-cycle `conv_start` on the current channel. `busy` rises in the cycle after the trigger and falls in the cycle after `conv_done`.
- R6: With `rd_scan_en`=1, one accepted trigger converts channels from `cur_chan` through the high limit, in pointer order. `busy` stays high until the `conv_done` of the high channel, and `cur_chan` then equals the low limit.
- R7: With `hw_trig_en`=0, only `sw_start` triggers. With `hw_trig_en`=1, `sw_start` is ignored. In that mode `hw_trig_sel`=0 selects `timer_tick` and `hw_trig_sel`=1 selects a rising edge of `ext_trig` after a two-stage synchronizer. A level that stays high triggers only once.
- R8: Triggers that arrive while `busy` is high are ignored and do not add conversions.
- R9: After reset, `busy`, `settling`, `conv_start`, `cur_chan`, `rd_lo`, `rd_hi`, `rd_scan_en` and `rd_gain` are all 0.
- R10: A pulse on `cfg_wr_ctl` stores `cfg_scan_en` and `cfg_gain` into `rd_scan_en`/`rd_gain`, visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_chan | input | 1 | Write strobe for the channel limits |
| cfg_lo | input | 4 | Low channel limit to store |
| cfg_hi | input | 4 | High channel limit to store |
| cfg_wr_ctl | input | 1 | Write strobe for scan enable and gain |
| cfg_scan_en | input | 1 | Scan enable to store |
| cfg_gain | input | 2 | Gain code to store |
| hw_trig_en | input | 1 | 1 selects a hardware trigger source |
| hw_trig_sel | input | 1 | Hardware source: 0 timer tick, 1 external pin |
| sw_start | input | 1 | Software start strobe |
| timer_tick | input | 1 | Synchronous timer trigger pulse |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | One-cycle conversion start to the converter |
| conv_chan | output | 4 | Channel for the conversion being started |
| busy | output | 1 | Conversion or scan in progress |
| settling | output | 1 | Settling window active, starts blocked |
| cur_chan | output | 4 | Channel the next conversion will sample |
| rd_lo | output | 4 | Stored low limit |
| rd_hi | output | 4 | Stored high limit |
| rd_scan_en | output | 1 | Stored scan enable |
| rd_gain | output | 2 | Stored gain code |

## Verification
The hardest cases to reach from the ports are the edges of the settling window. One is a trigger that lands in the very cycle of a configuration write. Another is a second write that arrives halfway through the window and must stretch it by a full period. Directed sequences cover both, cycle-exactly, by driving the strobes together and counting cycles from the last write. The wrapping range and multi-channel scans are then covered by seeded random limits and modes, and the conversion log kept by the converter model is compared with a channel sequence computed in the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;

  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_PIN   = 1'b1
  } hw_src_t;
endpackage

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int SETTLE_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic active
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;

  generate
    if (SETTLE_CYCLES == 0) begin : g_none
      assign active = 1'b0;
    end else begin : g_timer
      logic [CNT_W-1:0] cnt_q;
      logic             act_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
          act_q <= 1'b0;
        end else if (restart) begin
          cnt_q <= CNT_W'(SETTLE_CYCLES);
          act_q <= 1'b1;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          act_q <= (cnt_q != CNT_W'(1));
        end
      end
      assign active = act_q;
    end
  endgenerate
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_en,
  input  logic hw_sel,
  input  logic sw_start,
  input  logic timer_tick,
  input  logic pin_async,
  output logic trig
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_rise;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[gi] <= 1'b0;
        else if (gi == 0) sync_q[gi] <= pin_async;
        else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    if (!hw_en)                       trig = sw_start;
    else if (hw_src_t'(hw_sel) == SRC_PIN) trig = pin_rise;
    else                              trig = timer_tick;
  end
endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CH_W-1:0] lo_in,
  input  logic [CH_W-1:0] hi_in,
  input  logic            advance,
  output logic [CH_W-1:0] lo_q,
  output logic [CH_W-1:0] hi_q,
  output logic [CH_W-1:0] cur_q,
  output logic            cur_is_hi
);
  logic [CH_W-1:0] nxt;

  assign cur_is_hi = (cur_q == hi_q);
  assign nxt       = cur_is_hi ? lo_q : cur_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cur_q <= '0;
    end else if (load) begin
      lo_q  <= lo_in;
      hi_q  <= hi_in;
      cur_q <= lo_in;
    end else if (advance) begin
      cur_q <= nxt;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig,
  input  logic            blocked,
  input  logic            scan_en,
  input  logic            conv_done,
  input  logic [CH_W-1:0] cur_chan,
  input  logic            cur_is_hi,
  output logic            advance,
  output logic            busy,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan
);
  seq_state_t state_q;
  logic       last_hi_q;

  assign advance = (state_q == SQ_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      last_hi_q  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (trig && !blocked) begin
            state_q <= SQ_ISSUE;
            busy    <= 1'b1;
          end
        end
        SQ_ISSUE: begin
          conv_start <= 1'b1;
          conv_chan  <= cur_chan;
          last_hi_q  <= cur_is_hi;
          state_q    <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (conv_done) begin
            if (scan_en && !last_hi_q) begin
              state_q <= SQ_ISSUE;
            end else begin
              state_q <= SQ_IDLE;
              busy    <= 1'b0;
            end
          end
        end
        default: begin
          state_q <= SQ_IDLE;
          busy    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer #(
  parameter int CH_W          = 4,
  parameter int GAIN_W        = 2,
  parameter int SETTLE_CYCLES = 500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_chan,
  input  logic [CH_W-1:0]   cfg_lo,
  input  logic [CH_W-1:0]   cfg_hi,
  input  logic              cfg_wr_ctl,
  input  logic              cfg_scan_en,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic              hw_trig_en,
  input  logic              hw_trig_sel,
  input  logic              sw_start,
  input  logic              timer_tick,
  input  logic              ext_trig,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              busy,
  output logic              settling,
  output logic [CH_W-1:0]   cur_chan,
  output logic [CH_W-1:0]   rd_lo,
  output logic [CH_W-1:0]   rd_hi,
  output logic              rd_scan_en,
  output logic [GAIN_W-1:0] rd_gain
);
  logic any_wr;
  logic trig;
  logic advance;
  logic cur_is_hi;

  assign any_wr = cfg_wr_chan | cfg_wr_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_scan_en <= 1'b0;
      rd_gain    <= '0;
    end else if (cfg_wr_ctl) begin
      rd_scan_en <= cfg_scan_en;
      rd_gain    <= cfg_gain;
    end
  end

  adc_seq_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .restart (any_wr),
    .active  (settling)
  );

  adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk),
    .rst        (rst),
    .hw_en      (hw_trig_en),
    .hw_sel     (hw_trig_sel),
    .sw_start   (sw_start),
    .timer_tick (timer_tick),
    .pin_async  (ext_trig),
    .trig       (trig)
  );

  adc_seq_chan #(.CH_W(CH_W)) u_chan (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_wr_chan),
    .lo_in     (cfg_lo),
    .hi_in     (cfg_hi),
    .advance   (advance),
    .lo_q      (rd_lo),
    .hi_q      (rd_hi),
    .cur_q     (cur_chan),
    .cur_is_hi (cur_is_hi)
  );

  adc_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .blocked    (settling | any_wr),
    .scan_en    (rd_scan_en),
    .conv_done  (conv_done),
    .cur_chan   (cur_chan),
    .cur_is_hi  (cur_is_hi),
    .advance    (advance),
    .busy       (busy),
    .conv_start (conv_start),
    .conv_chan  (conv_chan)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_wr_chan,
  input logic            cfg_wr_ctl,
  input logic [CH_W-1:0] cfg_lo,
  input logic [CH_W-1:0] rd_lo,
  input logic [CH_W-1:0] rd_hi,
  input logic            conv_done,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            busy,
  input logic            settling,
  input logic [CH_W-1:0] cur_chan
);
  // R1: pointer and stored low limit follow a channel write
  assert_low_load_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_chan |=> (cur_chan == $past(cfg_lo) && rd_lo == $past(cfg_lo)));

  // R2: issuing the high channel sends the pointer back to the low limit
  assert_wrap_low_R2: assert property (@(posedge clk) disable iff (rst)
    (conv_start && conv_chan == rd_hi && !$past(cfg_wr_chan)) |-> cur_chan == rd_lo);

  // R3: any configuration write opens the settling window
  assert_settle_open_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_chan || cfg_wr_ctl) |=> settling);

  // R4: no start is accepted while settling or in a write cycle
  assert_settle_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && (settling || cfg_wr_chan || cfg_wr_ctl)) |=> !busy);

  // R5: a conversion start only happens under busy and lasts one cycle
  assert_start_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R5/R6: busy only ends after a converter completion
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(conv_done));
endmodule

bind adc_scan_sequencer adc_seq_checker #(.CH_W(CH_W)) u_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr_chan (cfg_wr_chan),
  .cfg_wr_ctl  (cfg_wr_ctl),
  .cfg_lo      (cfg_lo),
  .rd_lo       (rd_lo),
  .rd_hi       (rd_hi),
  .conv_done   (conv_done),
  .conv_start  (conv_start),
  .conv_chan   (conv_chan),
  .busy        (busy),
  .settling    (settling),
  .cur_chan    (cur_chan)
);

// File: tb/adc_scan_sequencer_test.sv
module adc_scan_sequencer_test;
  localparam int SETTLE = 500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_chan = 1'b0, cfg_wr_ctl = 1'b0, cfg_scan_en = 1'b0;
  logic [3:0] cfg_lo = '0, cfg_hi = '0;
  logic [1:0] cfg_gain = '0;
  logic       hw_trig_en = 1'b0, hw_trig_sel = 1'b0;
  logic       sw_start = 1'b0, timer_tick = 1'b0, ext_trig = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_start, busy, settling, rd_scan_en;
  logic [3:0] conv_chan, cur_chan, rd_lo, rd_hi;
  logic [1:0] rd_gain;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int log_ch [0:1023];
  int log_n = 0;
  int dcnt  = 0;
  int exp_a [0:31];
  int exp_len;
  int exp_cur;

  always #10 clk = ~clk;

  adc_scan_sequencer #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst(rst), .cfg_wr_chan(cfg_wr_chan), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_wr_ctl(cfg_wr_ctl), .cfg_scan_en(cfg_scan_en), .cfg_gain(cfg_gain),
    .hw_trig_en(hw_trig_en), .hw_trig_sel(hw_trig_sel), .sw_start(sw_start),
    .timer_tick(timer_tick), .ext_trig(ext_trig), .conv_done(conv_done),
    .conv_start(conv_start), .conv_chan(conv_chan), .busy(busy), .settling(settling),
    .cur_chan(cur_chan), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_scan_en(rd_scan_en),
    .rd_gain(rd_gain)
  );

  // converter model: logs each start, answers done three cycles later
  always @(negedge clk) begin
    if (rst) begin
      conv_done <= 1'b0;
      dcnt      <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        log_ch[log_n % 1024] <= int'(conv_chan);
        log_n <= log_n + 1;
        dcnt  <= 3;
      end else if (dcnt != 0) begin
        dcnt <= dcnt - 1;
        if (dcnt == 1) conv_done <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(input int c, input int lo, input int hi);
    return (c == hi) ? lo : (c + 1) % 16;
  endfunction

  // expected channels for one trigger from exp_cur
  task automatic build_exp(input bit scan, input int lo, input int hi);
    bit was_hi;
    exp_len = 0;
    do begin
      exp_a[exp_len] = exp_cur;
      exp_len++;
      was_hi  = (exp_cur == hi);
      exp_cur = nxt(exp_cur, lo, hi);
    end while (scan && !was_hi);
  endtask

  task automatic wr_chan(input int lo, input int hi);
    cfg_lo = 4'(lo); cfg_hi = 4'(hi); cfg_wr_chan = 1'b1;
    @(negedge clk);
    cfg_wr_chan = 1'b0;
  endtask

  task automatic wr_ctl(input bit scan, input int gain);
    cfg_scan_en = scan; cfg_gain = 2'(gain); cfg_wr_ctl = 1'b1;
    @(negedge clk);
    cfg_wr_ctl = 1'b0;
  endtask

  task automatic settle_out();
    repeat (SETTLE + 2) @(negedge clk);
  endtask

  task automatic pulse_sw();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while ((busy || dcnt != 0 || conv_done) && n < 600) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk({req, " run completes"}, int'(n < 600), 1);
  endtask

  task automatic cmp_run(input string req, input int start);
    chk({req, " conversion count"}, log_n - start, exp_len);
    for (int i = 0; i < exp_len; i++)
      chk({req, " channel order"}, log_ch[(start + i) % 1024], exp_a[i]);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int start;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7341);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 busy", busy, 0);
    chk("R9 settling", settling, 0);
    chk("R9 conv_start", conv_start, 0);
    chk("R9 cur_chan", cur_chan, 0);
    chk("R9 rd_lo/rd_hi", {rd_lo, rd_hi}, 0);
    chk("R9 rd_scan_en/rd_gain", {rd_scan_en, rd_gain}, 0);

    // R1 and R3: load limits, settling window length
    wr_chan(3, 5);
    chk("R1 rd_lo", rd_lo, 3);
    chk("R1 rd_hi", rd_hi, 5);
    chk("R1 cur_chan", cur_chan, 3);
    chk("R3 settling raised", settling, 1);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R3 settling last cycle", settling, 1);
    @(negedge clk);
    chk("R3 settling ended", settling, 0);

    // R3 retrigger halfway; R10 readback
    wr_ctl(1'b0, 3);
    chk("R10 rd_gain", rd_gain, 3);
    chk("R10 rd_scan_en", rd_scan_en, 0);
    repeat (SETTLE / 2) @(negedge clk);
    wr_ctl(1'b0, 1);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R3 retriggered window still open", settling, 1);
    @(negedge clk);
    chk("R3 retriggered window closed", settling, 0);

    // R4: start inside window and in the write cycle
    wr_chan(3, 5);
    start = log_n;
    repeat (10) @(negedge clk);
    pulse_sw();
    chk("R4 start during settling ignored", busy, 0);
    settle_out();
    cfg_wr_ctl = 1'b1; cfg_scan_en = 1'b0; cfg_gain = 2'd1; sw_start = 1'b1;
    @(negedge clk);
    cfg_wr_ctl = 1'b0; sw_start = 1'b0;
    chk("R4 start with write ignored", busy, 0);
    repeat (8) @(negedge clk);
    chk("R4 no conversions issued", log_n - start, 0);
    settle_out();

    // R5 and R2: single conversions 3,4,5,3,4
    exp_cur = 3;
    for (int k = 0; k < 5; k++) begin
      start = log_n;
      build_exp(1'b0, 3, 5);
      pulse_sw();
      chk("R5 busy rises after trigger", busy, 1);
      wait_idle("R5");
      cmp_run("R2 R5 single", start);
      chk("R2 cur_chan after advance", cur_chan, exp_cur);
    end

    // R2 wrap through 15 with low > high
    wr_chan(14, 2);
    settle_out();
    exp_cur = 14;
    for (int k = 0; k < 7; k++) begin
      start = log_n;
      build_exp(1'b0, 14, 2);
      pulse_sw();
      wait_idle("R2");
      cmp_run("R2 wrap", start);
    end

    // R8: trigger while busy ignored
    start = log_n;
    build_exp(1'b0, 14, 2);
    pulse_sw();
    @(negedge clk);
    pulse_sw();
    wait_idle("R8");
    repeat (4) @(negedge clk);
    cmp_run("R8 busy ignores trigger", start);

    // R6 scan 6..9 with busy profile
    wr_ctl(1'b1, 2);
    wr_chan(6, 9);
    settle_out();
    chk("R10 scan readback", rd_scan_en, 1);
    exp_cur = 6;
    start = log_n;
    build_exp(1'b1, 6, 9);
    pulse_sw();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (conv_done) begin
        chk("R6 busy across scan", busy, int'((log_n - start) < exp_len));
        if ((log_n - start) >= exp_len) break;
      end
    end
    wait_idle("R6");
    cmp_run("R6 scan", start);
    chk("R6 cur_chan back at low", cur_chan, 6);

    // R7 hardware modes
    wr_ctl(1'b0, 0);
    wr_chan(1, 4);
    settle_out();
    exp_cur = 1;
    hw_trig_en = 1'b1; hw_trig_sel = 1'b0;
    start = log_n;
    pulse_sw();
    repeat (6) @(negedge clk);
    chk("R7 sw_start ignored in hw mode", log_n - start, 0);
    build_exp(1'b0, 1, 4);
    timer_tick = 1'b1;
    @(negedge clk);
    timer_tick = 1'b0;
    wait_idle("R7");
    cmp_run("R7 timer trigger", start);
    hw_trig_sel = 1'b1;
    start = log_n;
    timer_tick = 1'b1;
    @(negedge clk);
    timer_tick = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 timer ignored with pin source", log_n - start, 0);
    build_exp(1'b0, 1, 4);
    ext_trig = 1'b1;
    repeat (30) @(negedge clk);
    wait_idle("R7");
    cmp_run("R7 pin edge triggers once", start);
    ext_trig = 1'b0;
    repeat (4) @(negedge clk);
    hw_trig_en = 1'b0; hw_trig_sel = 1'b0;

    // random limits and modes
    for (int it = 0; it < 24; it++) begin
      int lo, hi, ntr;
      bit sc;
      lo = int'($urandom % 16);
      hi = int'($urandom % 16);
      sc = 1'($urandom % 2);
      ntr = 1 + int'($urandom % 3);
      wr_ctl(sc, int'($urandom % 4));
      wr_chan(lo, hi);
      settle_out();
      exp_cur = lo;
      for (int t = 0; t < ntr; t++) begin
        start = log_n;
        build_exp(sc, lo, hi);
        pulse_sw();
        wait_idle("R6");
        cmp_run(sc ? "R6 random scan" : "R2 random single", start);
      end
      chk("R2 random cur_chan", cur_chan, exp_cur);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule